// File: doc/BRIEF.md
# Tree Route Computation Unit

This unit computes the route a packet takes through a k-ary tree network, where k is a power of two. Every node address is a string of radix-k digits, the top digit naming the branch taken below the root. Given a source and a destination address, the unit finds the highest digit position where the two differ. The packet must climb one level above that position to reach the closest shared ancestor. It then descends by following the destination's digits from that position down to digit zero.

A request carries both addresses over a valid/ready handshake. One clock edge later, a registered response presents three things: the climb count in digit levels, the descent port list ordered from the first hop to the last, and a mask marking which slots of that list are in use. Equal addresses give a climb of zero and an empty list, which means local delivery.

A two-state controller owns the response register. EMPTY means no response is held and FULL means one is held. The transitions are:
- IDLE: EMPTY stays EMPTY when no request arrives.
- ACCEPT: EMPTY moves to FULL when a request is taken.
- DRAIN: FULL moves to EMPTY when the response is taken and no new request arrives.
- REFILL: FULL stays FULL when the response is taken and a new request arrives in the same cycle.
- STALL: FULL stays FULL with the response frozen when the response is not taken.

Top module: `tree_route_unit`

## Requirements
- R1: While reset is applied and after it is released, rsp_valid is 0 and req_ready is 1 until the first request is taken.
- R2: rsp_up equals j+1, where j is the index of the most significant digit (digit 0 at the least significant end, each digit DIGIT_BITS wide) in which req_src and req_dst differ.
- R3: When req_src equals req_dst, rsp_up is 0, rsp_mask is 0 and rsp_path is 0 (local delivery).
- R4: For slot n < rsp_up, rsp_path[n*DIGIT_BITS +: DIGIT_BITS] holds destination digit rsp_up-1-n, so slot 0 is the first downward hop. Slots at or above rsp_up read 0.
- R5: rsp_mask bit n is 1 exactly when n < rsp_up.
- R6: A request taken at a clock edge (req_valid and req_ready both high) makes rsp_valid high, with its result, right after that edge.
- R7: While rsp_valid is high and rsp_ready is low, req_ready is low, and the response fields stay unchanged at the next edge.
- R8: Responses come out one per accepted request, in acceptance order, with no response lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_src | input | DIGIT_BITS*LEVELS | Source node address |
| req_dst | input | DIGIT_BITS*LEVELS | Destination node address |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_up | output | clog2(LEVELS+1) | Levels to climb |
| rsp_path | output | DIGIT_BITS*LEVELS | Downward child-port digits, first hop in slot 0 |
| rsp_mask | output | LEVELS | Slots of rsp_path in use |

## Verification
The bench builds the unit with DIGIT_BITS=2 and LEVELS=3, which gives a 4-ary tree of height three with 64 leaves. At that size every one of the 4096 source/destination pairs can be applied. This covers every climb count from 0 to 3, every digit value in every path slot, and every equal-address case. Random consumer back-pressure and random request gaps push the controller through all five transitions, including REFILL and long runs of STALL.

// File: rtl/tree_route_pkg.sv
package tree_route_pkg;
    typedef enum logic [0:0] {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/tree_digit_diff.sv
// Flags, per radix-k digit, whether source and destination disagree.
module tree_digit_diff #(
    parameter int DIGIT_BITS = 2,
    parameter int LEVELS     = 4,
    localparam int ADDR_W    = DIGIT_BITS * LEVELS
) (
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    output logic [LEVELS-1:0] differs
);
    logic [ADDR_W-1:0] rel;
    assign rel = src ^ dst;

    for (genvar g = 0; g < LEVELS; g++) begin : g_digit
        assign differs[g] = |rel[g*DIGIT_BITS +: DIGIT_BITS];
    end
endmodule

// File: rtl/tree_msd_finder.sv
// Returns one plus the index of the highest set flag, or zero if none is set.
module tree_msd_finder #(
    parameter int LEVELS = 4,
    localparam int LVL_W = $clog2(LEVELS + 1)
) (
    input  logic [LEVELS-1:0] flags,
    output logic [LVL_W-1:0]  up_count
);
    always_comb begin
        up_count = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (flags[i]) begin
                up_count = LVL_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/tree_path_select.sv
// Orders the low destination digits into hop slots, with the first hop in slot 0.
module tree_path_select #(
    parameter int DIGIT_BITS = 2,
    parameter int LEVELS     = 4,
    localparam int ADDR_W    = DIGIT_BITS * LEVELS,
    localparam int LVL_W     = $clog2(LEVELS + 1)
) (
    input  logic [ADDR_W-1:0] dst,
    input  logic [LVL_W-1:0]  up_count,
    output logic [ADDR_W-1:0] path,
    output logic [LEVELS-1:0] mask
);
    for (genvar n = 0; n < LEVELS; n++) begin : g_slot
        always_comb begin
            path[n*DIGIT_BITS +: DIGIT_BITS] = '0;
            // slot n carries digit j when up_count == n + j + 1
            for (int j = 0; j < LEVELS - n; j++) begin
                if (int'(up_count) == n + j + 1) begin
                    path[n*DIGIT_BITS +: DIGIT_BITS] = dst[j*DIGIT_BITS +: DIGIT_BITS];
                end
            end
        end
        assign mask[n] = (int'(up_count) > n);
    end
endmodule

// File: rtl/tree_route_unit.sv
module tree_route_unit
    import tree_route_pkg::*;
#(
    parameter int DIGIT_BITS = 2,
    parameter int LEVELS     = 4,
    localparam int ADDR_W    = DIGIT_BITS * LEVELS,
    localparam int LVL_W     = $clog2(LEVELS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_dst,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [LVL_W-1:0]  rsp_up,
    output logic [ADDR_W-1:0] rsp_path,
    output logic [LEVELS-1:0] rsp_mask
);
    slot_state_e state_q, state_d;

    logic [LEVELS-1:0] differs;
    logic [LVL_W-1:0]  up_d;
    logic [ADDR_W-1:0] path_d;
    logic [LEVELS-1:0] mask_d;
    logic              fire, take;

    tree_digit_diff #(.DIGIT_BITS(DIGIT_BITS), .LEVELS(LEVELS)) u_diff (
        .src     (req_src),
        .dst     (req_dst),
        .differs (differs)
    );

    tree_msd_finder #(.LEVELS(LEVELS)) u_msd (
        .flags    (differs),
        .up_count (up_d)
    );

    tree_path_select #(.DIGIT_BITS(DIGIT_BITS), .LEVELS(LEVELS)) u_path (
        .dst      (req_dst),
        .up_count (up_d),
        .path     (path_d),
        .mask     (mask_d)
    );

    // output process
    always_comb begin
        rsp_valid = (state_q == SLOT_FULL);
        req_ready = (state_q == SLOT_EMPTY) || rsp_ready;
    end

    assign fire = req_valid && req_ready;
    assign take = rsp_valid && rsp_ready;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (fire) state_d = SLOT_FULL;                 // ACCEPT / IDLE
            SLOT_FULL:  if (take && !fire) state_d = SLOT_EMPTY;       // DRAIN / REFILL / STALL
            default:    state_d = SLOT_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_up   <= '0;
            rsp_path <= '0;
            rsp_mask <= '0;
        end else if (fire) begin
            rsp_up   <= up_d;
            rsp_path <= path_d;
            rsp_mask <= mask_d;
        end
    end

    // R6: an accepted request yields a valid response right after the edge
    a_r6_response_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R7: a stalled response is held unchanged
    a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_up)
                                       && $stable(rsp_path) && $stable(rsp_mask)));

    // R5: the number of used slots equals the climb count
    a_r5_mask_count: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_mask) == int'(rsp_up)));

    // R5: the used slots are contiguous from slot 0
    a_r5_mask_contig: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((rsp_mask & (rsp_mask + 1'b1)) == '0));

    // R3: local delivery carries an empty path
    a_r3_local_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_up == '0) |-> (rsp_path == '0));
endmodule

// File: tb/tree_route_unit_test.sv
`timescale 1ns/1ps
module tree_route_unit_test;
    localparam int M      = 2;
    localparam int L      = 3;
    localparam int AW     = M * L;
    localparam int LW     = $clog2(L + 1);
    localparam int NODES  = 1 << AW;

    typedef struct packed {
        logic [LW-1:0] up;
        logic [AW-1:0] path;
        logic [L-1:0]  mask;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0] req_src = '0;
    logic [AW-1:0] req_dst = '0;
    logic rsp_valid;
    logic rsp_ready = 1'b0;
    logic [LW-1:0] rsp_up;
    logic [AW-1:0] rsp_path;
    logic [L-1:0]  rsp_mask;

    int checks = 0;
    int fails  = 0;
    bit drv_done = 1'b0;
    exp_t sb[$];

    always #2 clk = ~clk;

    tree_route_unit #(.DIGIT_BITS(M), .LEVELS(L)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_dst(req_dst),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_up(rsp_up), .rsp_path(rsp_path), .rsp_mask(rsp_mask)
    );

    // Reference model: scan digits from the root downward
    function automatic exp_t ref_route(logic [AW-1:0] a, logic [AW-1:0] b);
        exp_t e;
        int up = 0;
        e = '0;
        for (int lv = L - 1; lv >= 0; lv--) begin
            if (up == 0 && a[lv*M +: M] != b[lv*M +: M]) up = lv + 1;
        end
        e.up = LW'(up);
        for (int n = 0; n < up; n++) begin
            e.path[n*M +: M] = b[(up - 1 - n)*M +: M];
            e.mask[n] = 1'b1;
        end
        return e;
    endfunction

    task automatic check(string tag, bit ok, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(logic [AW-1:0] a, logic [AW-1:0] b);
        @(negedge clk);
        req_valid = 1'b1;
        req_src = a;
        req_dst = b;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        sb.push_back(ref_route(a, b));
    endtask

    // consumer back-pressure
    initial begin
        forever begin
            @(negedge clk);
            rsp_ready = ($urandom % 4) != 0;
        end
    end

    // monitor / scoreboard
    initial begin
        bit   stalled = 1'b0;
        exp_t held;
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                if (stalled) begin
                    check("R7 held", rsp_valid && rsp_up == held.up && rsp_path == held.path
                          && rsp_mask == held.mask, int'(rsp_path), int'(held.path));
                end
                stalled = 1'b0;
                if (rsp_valid && !rsp_ready) begin
                    check("R7 ready", req_ready == 1'b0, int'(req_ready), 0);
                    stalled = 1'b1;
                    held.up = rsp_up; held.path = rsp_path; held.mask = rsp_mask;
                end
                if (rsp_valid && rsp_ready) begin
                    if (sb.size() == 0) begin
                        check("R8 extra", 1'b0, 1, 0);
                    end else begin
                        e = sb.pop_front();
                        check(e.up == 0 ? "R3 up" : "R2 up", rsp_up == e.up, int'(rsp_up), int'(e.up));
                        check(e.up == 0 ? "R3 path" : "R4 path", rsp_path == e.path, int'(rsp_path), int'(e.path));
                        check("R5 mask", rsp_mask == e.mask, int'(rsp_mask), int'(e.mask));
                    end
                end
            end
        end
    end

    // driver
    initial begin
        #9;
        check("R1 valid in reset", rsp_valid == 1'b0, int'(rsp_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 valid", rsp_valid == 1'b0, int'(rsp_valid), 0);
        check("R1 ready", req_ready == 1'b1, int'(req_ready), 1);
        // R6: single isolated request appears right after acceptance
        send(AW'(5), AW'(9));
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        check("R6 latency", rsp_valid == 1'b1, int'(rsp_valid), 1);
        for (int a = 0; a < NODES; a++) begin
            for (int b = 0; b < NODES; b++) begin
                send(AW'(a), AW'(b));
                if (($urandom % 8) == 0) begin
                    @(negedge clk);
                    req_valid = 1'b0;
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 drained", sb.size() == 0 && !rsp_valid, sb.size(), 0);
        drv_done = 1'b1;
    end

    // finish and watchdog
    initial begin
        int cyc = 0;
        while (!drv_done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!drv_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule